// File: doc/BRIEF.md
# SATA Device-Side Out-of-Band Link Sequencer

This block is the control sequencer for the device end of a serial ATA link. It sits beside a multi-gigabit transceiver. The transceiver supplies dedicated strobes for host reset and wake bursts, plus a 32-bit parallel receive path with per-byte control-character flags. The block answers a host reset burst with a device init burst and a host wake burst with a device wake burst. It then streams ALIGN primitives until the host echoes ALIGN, and after that it reports the link as up while it transmits SYNC.

Around the burst exchange, the block controls the receiver's clock-recovery hold and receive reset. The hold is raised before the device init burst is requested and stays up until the host wake burst is detected. After the hold is released, the block applies a receive reset pulse of programmable length. It then waits for the transceiver to report that the reset is done before it looks for ALIGN. The electrical-idle flag is never consulted.

A host reset strobe restarts the handshake from any state, including after link-up. A wait for host ALIGN that lasts too long returns the sequencer to idle and sets a sticky timeout flag. Only the block reset clears that flag.

Top module: `sata_dev_oob_seq`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, every output is zero, including `timeoutFlag`, `txData` and `txCharIsK`.
- R2: A `rxComInitDet` strobe raises `rxCdrHold` one cycle before `txComInit`. `txComInit` is then high for exactly one clock, and the sequencer waits for `txComDone` before moving on.
- R3: `rxCdrHold` stays high until `rxComWakeDet` is seen after init completion. A wake strobe that arrives before init completion is ignored. The hold falls in the cycle in which `txComWake` is asserted.
- R4: `txComWake` is high for exactly one clock. After the next `txComDone`, `rxReset` is high for exactly `RST_LEN` consecutive cycles while `rxCdrHold` is low.
- R5: From the first `rxReset` cycle until link-up, `txData` is 0x7B4A4ABC with `txCharIsK` = 4'b0001 (bit 0 flags byte 0). Before that cycle, `txData` and `txCharIsK` are zero.
- R6: After the reset pulse, ALIGN detection starts only once `rxResetDone` is high. ALIGN received earlier has no effect.
- R7: A received word counts as ALIGN only when `rxData` = 0x7B4A4ABC and `rxCharIsK` = 4'b0001. Any other data, such as 0x4A4A4A4A, or ALIGN with another flag pattern, leaves `linkUp` low.
- R8: On a matching ALIGN, `linkUp` goes high in the next cycle and `txData` becomes 0x7B4A4ABC's successor primitive SYNC, 0xB5B5957C, with `txCharIsK` = 4'b0001.
- R9: If no ALIGN arrives within `ALIGN_WAIT` cycles of entering ALIGN detection, the sequencer returns to idle and sets `timeoutFlag`. An ALIGN in the last cycle of the window still succeeds. `timeoutFlag` stays set until `rstN`.
- R10: A `rxComInitDet` strobe in any state restarts the handshake. In the next cycle `rxCdrHold` is high, and `linkUp`, `txComInit` and `txData` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-side clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxComInitDet | input | 1 | Transceiver strobe: host reset burst detected |
| rxComWakeDet | input | 1 | Transceiver strobe: host wake burst detected |
| txComDone | input | 1 | Transceiver strobe: requested burst finished |
| rxResetDone | input | 1 | Transceiver receive reset completed |
| rxData | input | 32 | Received parallel word |
| rxCharIsK | input | 4 | Per-byte control-character flags of rxData |
| txComInit | output | 1 | One-clock request to send an init burst |
| txComWake | output | 1 | One-clock request to send a wake burst |
| rxCdrHold | output | 1 | Hold receive clock recovery |
| rxReset | output | 1 | Receive datapath reset pulse |
| txData | output | 32 | Transmit parallel word |
| txCharIsK | output | 4 | Per-byte control flags of txData |
| linkUp | output | 1 | Link established |
| timeoutFlag | output | 1 | Sticky: ALIGN wait expired |

## Verification
The hardest situations to reach are the edges of the ALIGN window and a restart from each deep state. Both require the whole burst exchange to be replayed first. The bench uses a single staged task that drives the exchange up to any chosen state. It then sweeps the restart strobe over all ten states and sweeps the arrival cycle of host ALIGN from the first cycle of the window to one cycle past its end. The expected link or timeout outcome is derived from the offset. A further run after a timeout shows that the sticky flag survives a later successful link.

// File: rtl/sata_oob_pkg.sv
package sata_oob_pkg;
  localparam logic [31:0] ALIGN_WORD = 32'h7B4A4ABC;
  localparam logic [31:0] SYNC_WORD  = 32'hB5B5957C;
  localparam logic [3:0]  K_BYTE0    = 4'b0001;

  typedef enum logic [1:0] {TX_IDLE, TX_ALIGN, TX_SYNC} txSel_e;

  // control -> datapath strobes
  typedef struct packed {
    txSel_e txSel;
    logic   rstRun;
    logic   timerRun;
  } dpCtrl_t;

  // datapath -> control status
  typedef struct packed {
    logic alignSeen;
    logic rstLast;
    logic timerLast;
  } dpStat_t;

  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_SEND_INIT, S_INIT_WAIT, S_WAKE_WAIT, S_SEND_WAKE,
    S_WAKEDONE_WAIT, S_RXRST, S_RSTDONE_WAIT, S_ALIGN_WAIT, S_LINK
  } oobState_e;
endpackage

// File: rtl/sata_oob_cnt.sv
module sata_oob_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic last
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [W-1:0] END_VAL = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN || !run) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign last = run && (cnt == END_VAL);
endmodule

// File: rtl/sata_oob_dp.sv
module sata_oob_dp
  import sata_oob_pkg::*;
#(
  parameter int RST_LEN    = 4,
  parameter int ALIGN_WAIT = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCtrl_t     ctl,
  input  logic [31:0] rxData,
  input  logic [3:0]  rxCharIsK,
  output dpStat_t     stat,
  output logic [31:0] txData,
  output logic [3:0]  txCharIsK
);
  logic rstLast, timerLast;

  sata_oob_cnt #(.LIMIT(RST_LEN)) rstCnt_i (
    .clk(clk), .rstN(rstN), .run(ctl.rstRun), .last(rstLast));

  sata_oob_cnt #(.LIMIT(ALIGN_WAIT)) waitCnt_i (
    .clk(clk), .rstN(rstN), .run(ctl.timerRun), .last(timerLast));

  always_comb begin
    stat.alignSeen = (rxData == ALIGN_WORD) && (rxCharIsK == K_BYTE0);
    stat.rstLast   = rstLast;
    stat.timerLast = timerLast;
  end

  always_comb begin
    unique case (ctl.txSel)
      TX_ALIGN: begin txData = ALIGN_WORD; txCharIsK = K_BYTE0; end
      TX_SYNC:  begin txData = SYNC_WORD;  txCharIsK = K_BYTE0; end
      default:  begin txData = '0;         txCharIsK = '0;      end
    endcase
  end
endmodule

// File: rtl/sata_oob_ctrl.sv
module sata_oob_ctrl
  import sata_oob_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rxComInitDet,
  input  logic    rxComWakeDet,
  input  logic    txComDone,
  input  logic    rxResetDone,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    txComInit,
  output logic    txComWake,
  output logic    rxCdrHold,
  output logic    rxReset,
  output logic    linkUp,
  output logic    timeoutFlag
);
  oobState_e state, nxt;

  always_comb begin
    nxt = state;
    if (rxComInitDet) nxt = S_HOLD;
    else begin
      unique case (state)
        S_IDLE:          nxt = S_IDLE;
        S_HOLD:          nxt = S_SEND_INIT;
        S_SEND_INIT:     nxt = S_INIT_WAIT;
        S_INIT_WAIT:     if (txComDone)      nxt = S_WAKE_WAIT;
        S_WAKE_WAIT:     if (rxComWakeDet)   nxt = S_SEND_WAKE;
        S_SEND_WAKE:     nxt = S_WAKEDONE_WAIT;
        S_WAKEDONE_WAIT: if (txComDone)      nxt = S_RXRST;
        S_RXRST:         if (stat.rstLast)   nxt = S_RSTDONE_WAIT;
        S_RSTDONE_WAIT:  if (rxResetDone)    nxt = S_ALIGN_WAIT;
        S_ALIGN_WAIT: begin
          if (stat.alignSeen)      nxt = S_LINK;
          else if (stat.timerLast) nxt = S_IDLE;
        end
        S_LINK:          nxt = S_LINK;
        default:         nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      timeoutFlag <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_ALIGN_WAIT && !rxComInitDet && !stat.alignSeen && stat.timerLast)
        timeoutFlag <= 1'b1;
    end
  end

  always_comb begin
    txComInit = (state == S_SEND_INIT);
    txComWake = (state == S_SEND_WAKE);
    rxCdrHold = (state == S_HOLD) || (state == S_SEND_INIT) ||
                (state == S_INIT_WAIT) || (state == S_WAKE_WAIT);
    rxReset   = (state == S_RXRST);
    linkUp    = (state == S_LINK);
    ctl.rstRun   = (state == S_RXRST);
    ctl.timerRun = (state == S_ALIGN_WAIT);
    if (state == S_LINK) ctl.txSel = TX_SYNC;
    else if (state == S_RXRST || state == S_RSTDONE_WAIT || state == S_ALIGN_WAIT)
      ctl.txSel = TX_ALIGN;
    else ctl.txSel = TX_IDLE;
  end
endmodule

// File: rtl/sata_dev_oob_seq.sv
module sata_dev_oob_seq
  import sata_oob_pkg::*;
#(
  parameter int RST_LEN    = 4,
  parameter int ALIGN_WAIT = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxComInitDet,
  input  logic        rxComWakeDet,
  input  logic        txComDone,
  input  logic        rxResetDone,
  input  logic [31:0] rxData,
  input  logic [3:0]  rxCharIsK,
  output logic        txComInit,
  output logic        txComWake,
  output logic        rxCdrHold,
  output logic        rxReset,
  output logic [31:0] txData,
  output logic [3:0]  txCharIsK,
  output logic        linkUp,
  output logic        timeoutFlag
);
  dpCtrl_t ctl;
  dpStat_t stat;

  sata_oob_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .rxComInitDet(rxComInitDet), .rxComWakeDet(rxComWakeDet),
    .txComDone(txComDone), .rxResetDone(rxResetDone), .stat(stat), .ctl(ctl),
    .txComInit(txComInit), .txComWake(txComWake), .rxCdrHold(rxCdrHold),
    .rxReset(rxReset), .linkUp(linkUp), .timeoutFlag(timeoutFlag));

  sata_oob_dp #(.RST_LEN(RST_LEN), .ALIGN_WAIT(ALIGN_WAIT)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxData(rxData), .rxCharIsK(rxCharIsK),
    .stat(stat), .txData(txData), .txCharIsK(txCharIsK));
endmodule

// File: rtl/sata_oob_chk.sv
module sata_oob_chk
  import sata_oob_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        rxComInitDet,
  input logic        rxComWakeDet,
  input logic        txComDone,
  input logic        rxResetDone,
  input logic [31:0] rxData,
  input logic [3:0]  rxCharIsK,
  input logic        txComInit,
  input logic        txComWake,
  input logic        rxCdrHold,
  input logic        rxReset,
  input logic [31:0] txData,
  input logic [3:0]  txCharIsK,
  input logic        linkUp,
  input logic        timeoutFlag
);
  p_init_one_clk_r2: assert property (@(posedge clk) disable iff (!rstN)
    txComInit |=> !txComInit);
  p_hold_before_init_r2: assert property (@(posedge clk) disable iff (!rstN)
    txComInit |-> (rxCdrHold && $past(rxCdrHold)));
  p_wake_drops_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    txComWake |-> !rxCdrHold);
  p_wake_one_clk_r4: assert property (@(posedge clk) disable iff (!rstN)
    txComWake |=> !txComWake);
  p_reset_no_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxReset |-> !rxCdrHold);
  p_align_during_reset_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxReset |-> (txData == ALIGN_WORD && txCharIsK == K_BYTE0));
  p_link_needs_align_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkUp) |-> ($past(rxData) == ALIGN_WORD && $past(rxCharIsK) == K_BYTE0));
  p_link_sends_sync_r8: assert property (@(posedge clk) disable iff (!rstN)
    linkUp |-> (txData == SYNC_WORD && txCharIsK == K_BYTE0));
  p_timeout_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag |=> timeoutFlag);
  p_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxComInitDet |=> (rxCdrHold && !linkUp && !txComInit));
endmodule

bind sata_dev_oob_seq sata_oob_chk chk_i (.*);

// File: tb/sata_dev_oob_seq_tb.sv
`timescale 1ns/1ps
module sata_dev_oob_seq_tb_top;
  localparam int RL = 3;
  localparam int AW = 8;
  localparam logic [31:0] ALIGN_W = 32'h7B4A4ABC;
  localparam logic [31:0] SYNC_W  = 32'hB5B5957C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxComInitDet = 0, rxComWakeDet = 0, txComDone = 0, rxResetDone = 0;
  logic [31:0] rxData = '0;
  logic [3:0]  rxCharIsK = '0;
  logic txComInit, txComWake, rxCdrHold, rxReset, linkUp, timeoutFlag;
  logic [31:0] txData;
  logic [3:0]  txCharIsK;

  int nChecks = 0;
  int nFail = 0;
  bit timedOut = 0;

  always #2.5 clk = ~clk;

  sata_dev_oob_seq #(.RST_LEN(RL), .ALIGN_WAIT(AW)) dut_i (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idleIn();
    rxComInitDet = 0; rxComWakeDet = 0; txComDone = 0;
    rxData = '0; rxCharIsK = '0;
  endtask

  // Drive the handshake up to stage n (1=hold .. 9=align wait, 10=link up)
  task automatic runTo(input int n);
    idleIn();
    rxComInitDet = 1; tick(); rxComInitDet = 0;
    chk("R2 hold first", rxCdrHold, 1); chk("R2 no init yet", txComInit, 0);
    if (n == 1) return;
    tick(); chk("R2 init req", txComInit, 1); chk("R2 hold with init", rxCdrHold, 1);
    if (n == 2) return;
    tick(); chk("R2 init one clk", txComInit, 0);
    rxComWakeDet = 1; tick(); rxComWakeDet = 0;
    tick(); chk("R3 early wake ignored", rxCdrHold, 1);
    chk("R5 idle tx", txData, 0);
    if (n == 3) return;
    txComDone = 1; tick(); txComDone = 0;
    tick(); tick(); chk("R3 hold kept", rxCdrHold, 1); chk("R4 no wake yet", txComWake, 0);
    if (n == 4) return;
    rxComWakeDet = 1; tick(); rxComWakeDet = 0;
    chk("R3 hold released", rxCdrHold, 0); chk("R4 wake req", txComWake, 1);
    chk("R5 no align before reset", txData, 0);
    if (n == 5) return;
    tick(); chk("R4 wake one clk", txComWake, 0); chk("R4 no reset before done", rxReset, 0);
    if (n == 6) return;
    rxResetDone = 0; txComDone = 1; tick(); txComDone = 0;
    chk("R4 reset start", rxReset, 1); chk("R5 align word", txData, ALIGN_W);
    chk("R5 align k", {28'd0, txCharIsK}, 32'h1);
    if (n == 7) return;
    for (int i = 1; i < RL; i++) begin tick(); chk("R4 reset held", rxReset, 1); end
    rxData = ALIGN_W; rxCharIsK = 4'b0001;
    tick(); chk("R4 reset length", rxReset, 0);
    if (n == 8) return;
    tick(); chk("R6 align before reset done ignored", linkUp, 0);
    rxData = '0; rxCharIsK = '0; rxResetDone = 1;
    tick(); chk("R6 still aligning", linkUp, 0); chk("R5 align kept", txData, ALIGN_W);
    if (n == 9) return;
    rxData = ALIGN_W; rxCharIsK = 4'b0001;
    tick(); rxData = '0; rxCharIsK = '0;
    chk("R8 link up", linkUp, 1); chk("R8 sync word", txData, SYNC_W);
    chk("R8 sync k", {28'd0, txCharIsK}, 32'h1);
  endtask

  initial begin
    #(200000 * 5);
    nFail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 reset txData", txData, 0);
    chk("R1 reset outputs", {26'd0, txComInit, txComWake, rxCdrHold, rxReset, linkUp, timeoutFlag}, 0);
    rstN = 1; tick();
    chk("R1 after reset", {26'd0, txComInit, txComWake, rxCdrHold, rxReset, linkUp, timeoutFlag}, 0);

    runTo(10);
    chk("R9 no timeout on success", timeoutFlag, 0);

    // R10: restart from every stage
    for (int s = 1; s <= 10; s++) begin
      runTo(s);
      rxComInitDet = 1; tick(); rxComInitDet = 0;
      chk("R10 restart hold", rxCdrHold, 1);
      chk("R10 restart link", linkUp, 0);
      chk("R10 restart tx", txData, 0);
      chk("R10 restart init", txComInit, 0);
    end

    // R7: non-matching words
    runTo(9);
    begin
      logic [31:0] badW [6];
      logic [3:0]  badK [6];
      badW[0] = 32'h4A4A4A4A; badK[0] = 4'b0000;
      badW[1] = 32'h4A4A4A4A; badK[1] = 4'b0001;
      badW[2] = ALIGN_W;      badK[2] = 4'b0000;
      badW[3] = ALIGN_W;      badK[3] = 4'b1111;
      badW[4] = ALIGN_W;      badK[4] = 4'b1000;
      badW[5] = SYNC_W;       badK[5] = 4'b0001;
      for (int b = 0; b < 6; b++) begin
        rxData = badW[b]; rxCharIsK = badK[b];
        tick(); chk("R7 mismatch ignored", linkUp, 0);
      end
    end
    rxData = ALIGN_W; rxCharIsK = 4'b0001;
    tick(); idleIn(); chk("R7 exact match", linkUp, 1);

    // R9: ALIGN arrival sweep across the window
    for (int k = 0; k <= AW; k++) begin
      runTo(9);
      for (int j = 0; j < k; j++) tick();
      rxData = ALIGN_W; rxCharIsK = 4'b0001;
      tick(); idleIn();
      if (k == AW) timedOut = 1;
      chk("R9 window outcome", linkUp, (k < AW) ? 1 : 0);
      chk("R9 timeout flag", timeoutFlag, timedOut ? 1 : 0);
      if (k == AW) chk("R9 idle tx after timeout", txData, 0);
    end

    runTo(10);
    chk("R9 flag sticky", timeoutFlag, 1);

    rstN = 0; tick();
    chk("R1 reset clears flag", timeoutFlag, 0);
    chk("R1 reset clears link", linkUp, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule